// File: doc/BRIEF.md
# Priority Interrupt Presentation Controller

This block sits beside one processor and presents at most one interrupt to it at a time. Source controllers offer interrupts, each carrying a 24-bit source number, an 8-bit priority and the identity of the offering controller. A numerically lower priority is more favored. The block keeps the single best pending interrupt and remembers which controller owns it. It drives one interrupt line to the processor. When an interrupt cannot be kept, it hands it back: an offer that is turned away is answered on a refusal channel, and an interrupt that loses its slot is returned to its owner on a separate displacement channel.

Software reaches the block through a one-cycle command port. The commands are: set the processor priority, set the inter-processor request priority, accept (read and take) the pending interrupt, poll without side effects, and end-of-interrupt. A software inter-processor request can preempt a less favored pending interrupt. It uses a reserved source number and has no owner. End-of-interrupt notifications are forwarded by source number. When the slot is left empty, a one-cycle resend request asks every source to offer again.

The status word is 32 bits: the processor priority sits in bits 31:24 and the pending source number in bits 23:0. A source field of zero means nothing is pending. Every state change and every output pulse appears one clock after the command or offer that caused it.

Top module: `intp_present`

## Requirements
- R1: After reset, and at once while rst_n is low, irq_out is 0, the status word reads 0x00000000 and the inter-processor request priority reads 0xFF.
- R2: An offer (offer_valid with source in offer_src and priority in offer_prio) is refused when its priority is greater than or equal to the processor priority, or when an interrupt is pending whose priority is less than or equal to the offered one. A refusal pulses nak_valid one cycle later, with nak_src and nak_owner echoing the offer.
- R3: A taken offer first returns any owned pending interrupt to its owner. This is a rej_valid pulse with rej_src and rej_owner, one cycle later. The offer then becomes the pending interrupt with its source, priority and owner, and irq_out rises.
- R4: Command 3 (accept) pulses rd_valid with rd_data equal to the status word and lowers irq_out. Afterwards the status word holds the old pending priority in bits 31:24 and zero in bits 23:0, and the pending priority is 0xFF with no owner.
- R5: Command 4 (poll) pulses rd_valid with rd_data equal to the status word and rd_ipr equal to the request priority. It changes no state.
- R6: Command 1 sets the processor priority from cmd_wdata[7:0]. If the new value is numerically lower, and a pending interrupt has a priority greater than or equal to the new value, that interrupt is cleared: the source field becomes 0, irq_out falls, and it is returned to its owner if it has one.
- R7: When command 1 writes a value greater than or equal to the old processor priority while nothing is pending, resend_req pulses. If the request priority is then below the processor priority, the inter-processor request is loaded.
- R8: Command 2 sets the request priority from cmd_wdata[7:0]. If the new value is below the processor priority, the request takes the slot, unless the pending priority is less than or equal to it. Taking the slot returns any owned interrupt to its owner, loads source number IPI_SRC (default 2) with no owner, sets the pending priority to the request value and raises irq_out.
- R9: Command 5 (end-of-interrupt) copies cmd_wdata[31:24] into the processor priority. It pulses eoi_valid with eoi_src = cmd_wdata[23:0], except when that number is 0 or IPI_SRC. If nothing is pending, it then behaves as the resend of R7.
- R10: An inter-processor interrupt has no owner, so clearing it or displacing it never produces a rej_valid pulse.
- R11: An offer arriving in a cycle with cmd_valid high is not taken and is refused as in R2. An offer with source number 0 is ignored entirely: no refusal, no state change.
- R12: irq_out is high exactly when the source field of the status word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| offer_valid | input | 1 | An interrupt offer is presented this cycle |
| offer_src | input | 24 | Source number of the offer |
| offer_prio | input | 8 | Priority of the offer, lower is more favored |
| offer_owner | input | 4 | Identity of the offering source controller |
| cmd_valid | input | 1 | A software command is presented this cycle |
| cmd_op | input | 3 | Command: 1 processor priority, 2 request priority, 3 accept, 4 poll, 5 end-of-interrupt |
| cmd_wdata | input | 32 | Command write data |
| irq_out | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | Read data valid pulse for accept and poll |
| rd_data | output | 32 | Status word returned by accept or poll |
| rd_ipr | output | 8 | Request priority returned with a read |
| nak_valid | output | 1 | Pulse: an offer was refused |
| nak_src | output | 24 | Source number of the refused offer |
| nak_owner | output | 4 | Controller that made the refused offer |
| rej_valid | output | 1 | Pulse: a pending interrupt was displaced or cleared |
| rej_src | output | 24 | Source number returned |
| rej_owner | output | 4 | Controller that owns the returned interrupt |
| eoi_valid | output | 1 | Pulse: end-of-interrupt notification |
| eoi_src | output | 24 | Source number being ended |
| resend_req | output | 1 | Pulse: all sources are asked to offer again |

## Verification
The hardest state to reach from the ports is an inter-processor request that occupies the slot and is then cleared, accepted or loaded again through the resend path of an end-of-interrupt. In that state no displacement or end notification may appear, even though the same commands produce them for an owned interrupt. Getting there needs a precise order. An owned interrupt must be pending, then be preempted by a request priority below both the pending and the processor priority, and then the processor priority is lowered onto the request value. The stimulus table is a single chained sequence that walks through this order step by step. Boundary equalities (offer priority equal to the pending or processor priority, clear on an equal priority) sit between the steps, and a final directed step issues a poll and an offer in the same cycle.

// File: rtl/intp_pkg.sv
package intp_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE     = 3'd0,
    OP_SET_PRIO = 3'd1,
    OP_SET_IPR  = 3'd2,
    OP_ACCEPT   = 3'd3,
    OP_POLL     = 3'd4,
    OP_EOI      = 3'd5
  } op_e;
endpackage

// File: rtl/intp_rst_sync.sv
module intp_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/intp_ipi_check.sv
module intp_ipi_check #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input  logic [SRC_W-1:0]  pend_src,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] ipr_prio,
  input  logic [PRIO_W-1:0] gate_prio,
  output logic              take,
  output logic              displace
);
  logic below_gate;
  logic held_better;

  always_comb begin
    below_gate  = (ipr_prio < gate_prio);
    held_better = (pend_src != '0) && (pend_prio <= ipr_prio);
    take        = below_gate && !held_better;
    displace    = take && (pend_src != '0);
  end
endmodule

// File: rtl/intp_offer_unit.sv
module intp_offer_unit #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic              blocked,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [SRC_W-1:0]  pend_src,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              own_v,
  output logic              take,
  output logic              nak,
  output logic              displace
);
  logic live;
  logic refuse;

  always_comb begin
    live     = offer_valid && (offer_src != '0);
    refuse   = (offer_prio >= cur_prio) ||
               ((pend_src != '0) && (pend_prio <= offer_prio));
    take     = live && !blocked && !refuse;
    nak      = live && (blocked || refuse);
    displace = take && (pend_src != '0) && own_v;
  end
endmodule

// File: rtl/intp_cmd_unit.sv
module intp_cmd_unit
  import intp_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int OWN_W   = 4,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [SRC_W-1:0]  pend_src,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] ipr_prio,
  input  logic              own_v,
  input  logic [OWN_W-1:0]  own_id,
  input  logic              irq_cur,
  output logic [PRIO_W-1:0] n_cur_prio,
  output logic [SRC_W-1:0]  n_pend_src,
  output logic [PRIO_W-1:0] n_pend_prio,
  output logic [PRIO_W-1:0] n_ipr_prio,
  output logic              n_own_v,
  output logic              n_irq,
  output logic              rej_v,
  output logic [SRC_W-1:0]  rej_src,
  output logic [OWN_W-1:0]  rej_own,
  output logic              eoi_v,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              resend,
  output logic              rd_v,
  output logic [WORD_W-1:0] rd_word
);
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  op_e               op;
  logic [PRIO_W-1:0] wr_low;
  logic [PRIO_W-1:0] wr_high;
  logic [SRC_W-1:0]  wr_src;
  logic [PRIO_W-1:0] rs_gate;
  logic              ipr_take, ipr_disp;
  logic              rs_take, rs_disp;

  assign op      = op_e'(cmd_op);
  assign wr_low  = cmd_wdata[PRIO_W-1:0];
  assign wr_high = cmd_wdata[WORD_W-1:SRC_W];
  assign wr_src  = cmd_wdata[SRC_W-1:0];
  assign rs_gate = (op == OP_EOI) ? wr_high : wr_low;

  // Request path: new request value against the present processor priority.
  intp_ipi_check #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_ipr_chk (
    .pend_src (pend_src),
    .pend_prio(pend_prio),
    .ipr_prio (wr_low),
    .gate_prio(cur_prio),
    .take     (ipr_take),
    .displace (ipr_disp)
  );

  // Resend path: present request value against the newly written priority.
  intp_ipi_check #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_rs_chk (
    .pend_src (pend_src),
    .pend_prio(pend_prio),
    .ipr_prio (ipr_prio),
    .gate_prio(rs_gate),
    .take     (rs_take),
    .displace (rs_disp)
  );

  always_comb begin
    n_cur_prio  = cur_prio;
    n_pend_src  = pend_src;
    n_pend_prio = pend_prio;
    n_ipr_prio  = ipr_prio;
    n_own_v     = own_v;
    n_irq       = irq_cur;
    rej_v       = 1'b0;
    rej_src     = '0;
    rej_own     = '0;
    eoi_v       = 1'b0;
    eoi_src     = '0;
    resend      = 1'b0;
    rd_v        = 1'b0;
    rd_word     = {cur_prio, pend_src};
    if (cmd_valid) begin
      unique case (op)
        OP_SET_PRIO: begin
          n_cur_prio = wr_low;
          if (wr_low < cur_prio) begin
            if ((pend_src != '0) && (wr_low <= pend_prio)) begin
              n_pend_src  = '0;
              n_pend_prio = PRIO_NONE;
              n_irq       = 1'b0;
              n_own_v     = 1'b0;
              if (own_v) begin
                rej_v   = 1'b1;
                rej_src = pend_src;
                rej_own = own_id;
              end
            end
          end else if (pend_src == '0) begin
            resend = 1'b1;
            if (rs_take) begin
              n_pend_src  = IPI_NUM;
              n_pend_prio = ipr_prio;
              n_own_v     = 1'b0;
              n_irq       = 1'b1;
            end
          end
        end
        OP_SET_IPR: begin
          n_ipr_prio = wr_low;
          if (ipr_take) begin
            if (ipr_disp && own_v) begin
              rej_v   = 1'b1;
              rej_src = pend_src;
              rej_own = own_id;
            end
            n_pend_src  = IPI_NUM;
            n_pend_prio = wr_low;
            n_own_v     = 1'b0;
            n_irq       = 1'b1;
          end
        end
        OP_ACCEPT: begin
          rd_v        = 1'b1;
          n_cur_prio  = pend_prio;
          n_pend_src  = '0;
          n_pend_prio = PRIO_NONE;
          n_own_v     = 1'b0;
          n_irq       = 1'b0;
        end
        OP_POLL: begin
          rd_v = 1'b1;
        end
        OP_EOI: begin
          n_cur_prio = wr_high;
          eoi_v      = (wr_src != '0) && (wr_src != IPI_NUM);
          eoi_src    = wr_src;
          if (pend_src == '0) begin
            resend = 1'b1;
            if (rs_take) begin
              n_pend_src  = IPI_NUM;
              n_pend_prio = ipr_prio;
              n_own_v     = 1'b0;
              n_irq       = 1'b1;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  // Resend only runs with an empty slot, so it can never displace.
  // R7
  always_comb begin
    resend_no_disp_chk: assert (!(cmd_valid && resend && rs_take && rs_disp));
  end
endmodule

// File: rtl/intp_regs.sv
module intp_regs #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24,
  parameter int OWN_W  = 4,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [PRIO_W-1:0] nx_cur_prio,
  input  logic [SRC_W-1:0]  nx_pend_src,
  input  logic [PRIO_W-1:0] nx_pend_prio,
  input  logic [PRIO_W-1:0] nx_ipr_prio,
  input  logic              nx_own_v,
  input  logic [OWN_W-1:0]  nx_own_id,
  input  logic              nx_irq,
  input  logic              nx_rej_v,
  input  logic [SRC_W-1:0]  nx_rej_src,
  input  logic [OWN_W-1:0]  nx_rej_own,
  input  logic              nx_nak_v,
  input  logic [SRC_W-1:0]  nx_nak_src,
  input  logic [OWN_W-1:0]  nx_nak_own,
  input  logic              nx_eoi_v,
  input  logic [SRC_W-1:0]  nx_eoi_src,
  input  logic              nx_resend,
  input  logic              nx_rd_v,
  input  logic [WORD_W-1:0] nx_rd_word,
  output logic [PRIO_W-1:0] cur_prio_q,
  output logic [SRC_W-1:0]  pend_src_q,
  output logic [PRIO_W-1:0] pend_prio_q,
  output logic [PRIO_W-1:0] ipr_prio_q,
  output logic              own_v_q,
  output logic [OWN_W-1:0]  own_id_q,
  output logic              irq_q,
  output logic              rej_v_q,
  output logic [SRC_W-1:0]  rej_src_q,
  output logic [OWN_W-1:0]  rej_own_q,
  output logic              nak_v_q,
  output logic [SRC_W-1:0]  nak_src_q,
  output logic [OWN_W-1:0]  nak_own_q,
  output logic              eoi_v_q,
  output logic [SRC_W-1:0]  eoi_src_q,
  output logic              resend_q,
  output logic              rd_v_q,
  output logic [WORD_W-1:0] rd_word_q,
  output logic [PRIO_W-1:0] rd_ipr_q
);
  // Slot state, written only when a command or a taken offer commits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_prio_q  <= '0;
      pend_src_q  <= '0;
      pend_prio_q <= '1;
      ipr_prio_q  <= '1;
      own_v_q     <= 1'b0;
      own_id_q    <= '0;
      irq_q       <= 1'b0;
    end else if (upd_en) begin
      cur_prio_q  <= nx_cur_prio;
      pend_src_q  <= nx_pend_src;
      pend_prio_q <= nx_pend_prio;
      ipr_prio_q  <= nx_ipr_prio;
      own_v_q     <= nx_own_v;
      own_id_q    <= nx_own_id;
      irq_q       <= nx_irq;
    end
  end

  // Single-cycle notification pulses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_v_q   <= 1'b0;
      rej_src_q <= '0;
      rej_own_q <= '0;
      nak_v_q   <= 1'b0;
      nak_src_q <= '0;
      nak_own_q <= '0;
      eoi_v_q   <= 1'b0;
      eoi_src_q <= '0;
      resend_q  <= 1'b0;
      rd_v_q    <= 1'b0;
    end else begin
      rej_v_q   <= nx_rej_v;
      rej_src_q <= nx_rej_src;
      rej_own_q <= nx_rej_own;
      nak_v_q   <= nx_nak_v;
      nak_src_q <= nx_nak_src;
      nak_own_q <= nx_nak_own;
      eoi_v_q   <= nx_eoi_v;
      eoi_src_q <= nx_eoi_src;
      resend_q  <= nx_resend;
      rd_v_q    <= nx_rd_v;
    end
  end

  // Read data, captured only on a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word_q <= '0;
      rd_ipr_q  <= '1;
    end else if (nx_rd_v) begin
      rd_word_q <= nx_rd_word;
      rd_ipr_q  <= ipr_prio_q;
    end
  end

  // R12
  irq_tracks_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (pend_src_q != '0));

  // R4
  empty_prio_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_src_q == '0) |-> (pend_prio_q == '1));

  // R10
  rej_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_v_q |-> $past(own_v_q));
endmodule

// File: rtl/intp_present.sv
module intp_present
  import intp_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int OWN_W   = 4,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic [OWN_W-1:0]  offer_owner,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              irq_out,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [PRIO_W-1:0] rd_ipr,
  output logic              nak_valid,
  output logic [SRC_W-1:0]  nak_src,
  output logic [OWN_W-1:0]  nak_owner,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic [OWN_W-1:0]  rej_owner,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              resend_req
);
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic              rst_int_n;
  logic [PRIO_W-1:0] cur_prio_q, pend_prio_q, ipr_prio_q;
  logic [SRC_W-1:0]  pend_src_q;
  logic              own_v_q, irq_q;
  logic [OWN_W-1:0]  own_id_q;

  logic [PRIO_W-1:0] c_cur_prio, c_pend_prio, c_ipr_prio;
  logic [SRC_W-1:0]  c_pend_src, c_rej_src, c_eoi_src;
  logic              c_own_v, c_irq, c_rej_v, c_eoi_v, c_resend, c_rd_v;
  logic [OWN_W-1:0]  c_rej_own;
  logic [WORD_W-1:0] c_rd_word;

  logic              o_take, o_nak, o_disp;

  logic [PRIO_W-1:0] nx_cur_prio, nx_pend_prio, nx_ipr_prio;
  logic [SRC_W-1:0]  nx_pend_src, nx_rej_src;
  logic              nx_own_v, nx_irq, nx_rej_v, upd_en;
  logic [OWN_W-1:0]  nx_own_id, nx_rej_own;

  intp_rst_sync u_rst (
    .clk   (clk),
    .rst_ni(rst_n),
    .rst_no(rst_int_n)
  );

  intp_cmd_unit #(
    .PRIO_W(PRIO_W), .SRC_W(SRC_W), .OWN_W(OWN_W), .IPI_SRC(IPI_SRC)
  ) u_cmd (
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_wdata  (cmd_wdata),
    .cur_prio   (cur_prio_q),
    .pend_src   (pend_src_q),
    .pend_prio  (pend_prio_q),
    .ipr_prio   (ipr_prio_q),
    .own_v      (own_v_q),
    .own_id     (own_id_q),
    .irq_cur    (irq_q),
    .n_cur_prio (c_cur_prio),
    .n_pend_src (c_pend_src),
    .n_pend_prio(c_pend_prio),
    .n_ipr_prio (c_ipr_prio),
    .n_own_v    (c_own_v),
    .n_irq      (c_irq),
    .rej_v      (c_rej_v),
    .rej_src    (c_rej_src),
    .rej_own    (c_rej_own),
    .eoi_v      (c_eoi_v),
    .eoi_src    (c_eoi_src),
    .resend     (c_resend),
    .rd_v       (c_rd_v),
    .rd_word    (c_rd_word)
  );

  intp_offer_unit #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_offer (
    .offer_valid(offer_valid),
    .offer_src  (offer_src),
    .offer_prio (offer_prio),
    .blocked    (cmd_valid),
    .cur_prio   (cur_prio_q),
    .pend_src   (pend_src_q),
    .pend_prio  (pend_prio_q),
    .own_v      (own_v_q),
    .take       (o_take),
    .nak        (o_nak),
    .displace   (o_disp)
  );

  // A command owns the cycle; otherwise a taken offer commits.
  always_comb begin
    upd_en       = cmd_valid || o_take;
    nx_cur_prio  = c_cur_prio;
    nx_pend_src  = c_pend_src;
    nx_pend_prio = c_pend_prio;
    nx_ipr_prio  = c_ipr_prio;
    nx_own_v     = c_own_v;
    nx_own_id    = own_id_q;
    nx_irq       = c_irq;
    nx_rej_v     = c_rej_v;
    nx_rej_src   = c_rej_src;
    nx_rej_own   = c_rej_own;
    if (!cmd_valid && o_take) begin
      nx_pend_src  = offer_src;
      nx_pend_prio = offer_prio;
      nx_own_v     = 1'b1;
      nx_own_id    = offer_owner;
      nx_irq       = 1'b1;
      nx_rej_v     = o_disp;
      nx_rej_src   = o_disp ? pend_src_q : '0;
      nx_rej_own   = o_disp ? own_id_q : '0;
    end
  end

  intp_regs #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .OWN_W(OWN_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .upd_en      (upd_en),
    .nx_cur_prio (nx_cur_prio),
    .nx_pend_src (nx_pend_src),
    .nx_pend_prio(nx_pend_prio),
    .nx_ipr_prio (nx_ipr_prio),
    .nx_own_v    (nx_own_v),
    .nx_own_id   (nx_own_id),
    .nx_irq      (nx_irq),
    .nx_rej_v    (nx_rej_v),
    .nx_rej_src  (nx_rej_src),
    .nx_rej_own  (nx_rej_own),
    .nx_nak_v    (o_nak),
    .nx_nak_src  (o_nak ? offer_src : '0),
    .nx_nak_own  (o_nak ? offer_owner : '0),
    .nx_eoi_v    (c_eoi_v),
    .nx_eoi_src  (c_eoi_v ? c_eoi_src : '0),
    .nx_resend   (c_resend),
    .nx_rd_v     (c_rd_v),
    .nx_rd_word  (c_rd_word),
    .cur_prio_q  (cur_prio_q),
    .pend_src_q  (pend_src_q),
    .pend_prio_q (pend_prio_q),
    .ipr_prio_q  (ipr_prio_q),
    .own_v_q     (own_v_q),
    .own_id_q    (own_id_q),
    .irq_q       (irq_q),
    .rej_v_q     (rej_valid),
    .rej_src_q   (rej_src),
    .rej_own_q   (rej_owner),
    .nak_v_q     (nak_valid),
    .nak_src_q   (nak_src),
    .nak_own_q   (nak_owner),
    .eoi_v_q     (eoi_valid),
    .eoi_src_q   (eoi_src),
    .resend_q    (resend_req),
    .rd_v_q      (rd_valid),
    .rd_word_q   (rd_data),
    .rd_ipr_q    (rd_ipr)
  );

  assign irq_out = irq_q;

  // R4
  accept_lowers_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && cmd_op == OP_ACCEPT) |=> (!irq_out && pend_src_q == '0));

  // R5
  poll_stable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && cmd_op == OP_POLL) |=>
      ($stable(pend_src_q) && $stable(cur_prio_q) && $stable(ipr_prio_q) && $stable(irq_q)));

  // R11
  offer_blocked_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && offer_valid && offer_src != '0) |=> nak_valid);

  // R9
  eoi_number_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    eoi_valid |-> (eoi_src != '0 && eoi_src != IPI_NUM));

  // R3
  one_notice_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(nak_valid && rej_valid && nak_src == rej_src && nak_owner == rej_owner && nak_src != '0
      && !$past(cmd_valid)));
endmodule

// File: tb/intp_present_tb.sv
`timescale 1ns/1ps
module intp_present_tb;
  logic        clk;
  logic        rst_n;
  logic        offer_valid;
  logic [23:0] offer_src;
  logic [7:0]  offer_prio;
  logic [3:0]  offer_owner;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_wdata;
  logic        irq_out, rd_valid, nak_valid, rej_valid, eoi_valid, resend_req;
  logic [31:0] rd_data;
  logic [7:0]  rd_ipr;
  logic [23:0] nak_src, rej_src, eoi_src;
  logic [3:0]  nak_owner, rej_owner;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  intp_present u_dut (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
    .offer_owner(offer_owner),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .irq_out(irq_out), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ipr(rd_ipr),
    .nak_valid(nak_valid), .nak_src(nak_src), .nak_owner(nak_owner),
    .rej_valid(rej_valid), .rej_src(rej_src), .rej_owner(rej_owner),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [2:0]  kind;   // 0 offer, else command code
    logic [31:0] w;      // offer: {prio, src}; command: write data
    logic [3:0]  own;
    logic [3:0]  req;
    logic        e_irq;
    logic        e_nak;
    logic        e_rej;
    logic [23:0] e_rsrc;
    logic [3:0]  e_rown;
    logic        e_eoi;
    logic [23:0] e_esrc;
    logic        e_res;
    logic [31:0] e_rd;
    logic [7:0]  e_ipr;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    // R2 priority 0 processor level refuses everything
    '{3'd0, 32'h05000010, 4'd1, 4'd2,  1'b0, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R7 raise processor priority with empty slot
    '{3'd1, 32'h000000FF, 4'd0, 4'd7,  1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b1, 32'h0, 8'h00},
    // R3 first offer taken
    '{3'd0, 32'h05000010, 4'd1, 4'd3,  1'b1, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R2 less favored than pending
    '{3'd0, 32'h07000020, 4'd2, 4'd2,  1'b1, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R3 better offer displaces owner 1
    '{3'd0, 32'h03000030, 4'd3, 4'd3,  1'b1, 1'b0, 1'b1, 24'h10, 4'd1, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R5 poll
    '{3'd4, 32'h0,        4'd0, 4'd5,  1'b1, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'hFF000030, 8'hFF},
    // R2 equal to pending priority
    '{3'd0, 32'h03000040, 4'd4, 4'd2,  1'b1, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R4 accept
    '{3'd3, 32'h0,        4'd0, 4'd4,  1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'hFF000030, 8'hFF},
    // R4 word after accept
    '{3'd4, 32'h0,        4'd0, 4'd4,  1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h03000000, 8'hFF},
    // R2 equal to processor priority
    '{3'd0, 32'h03000050, 4'd5, 4'd2,  1'b0, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R3 offer below processor priority
    '{3'd0, 32'h02000050, 4'd5, 4'd3,  1'b1, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R9 end of 0x30, slot still full
    '{3'd5, 32'hFF000030, 4'd0, 4'd9,  1'b1, 1'b0, 1'b0, 24'h0,  4'd0, 1'b1, 24'h30, 1'b0, 32'h0, 8'h00},
    // R12 poll with line high
    '{3'd4, 32'h0,        4'd0, 4'd12, 1'b1, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'hFF000050, 8'hFF},
    // R8 request not better than pending
    '{3'd2, 32'h00000004, 4'd0, 4'd8,  1'b1, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R8 request preempts owner 5
    '{3'd2, 32'h00000001, 4'd0, 4'd8,  1'b1, 1'b0, 1'b1, 24'h50, 4'd5, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R8 reserved number loaded
    '{3'd4, 32'h0,        4'd0, 4'd8,  1'b1, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'hFF000002, 8'h01},
    // R2 equal to request priority
    '{3'd0, 32'h01000060, 4'd6, 4'd2,  1'b1, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R10 R6 clearing the request gives no return
    '{3'd1, 32'h00000001, 4'd0, 4'd10, 1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R6 word after clear
    '{3'd4, 32'h0,        4'd0, 4'd6,  1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h01000000, 8'h01},
    // R9 R10 end of reserved number: no notice, resend reloads request
    '{3'd5, 32'hFF000002, 4'd0, 4'd10, 1'b1, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b1, 32'h0, 8'h00},
    // R4 accept request
    '{3'd3, 32'h0,        4'd0, 4'd4,  1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'hFF000002, 8'h01},
    // R8 request not below processor priority
    '{3'd2, 32'h000000FF, 4'd0, 4'd8,  1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R9 end with empty slot resends
    '{3'd5, 32'hFF000002, 4'd0, 4'd9,  1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b1, 32'h0, 8'h00},
    // R3 owner 7
    '{3'd0, 32'h09000070, 4'd7, 4'd3,  1'b1, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R6 lower priority, pending still more favored
    '{3'd1, 32'h00000020, 4'd0, 4'd6,  1'b1, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R6 lower onto equal value clears and returns to owner 7
    '{3'd1, 32'h00000009, 4'd0, 4'd6,  1'b0, 1'b0, 1'b1, 24'h70, 4'd7, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R11 source 0 ignored
    '{3'd0, 32'h01000000, 4'd1, 4'd11, 1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0, 8'h00},
    // R11 nothing changed
    '{3'd4, 32'h0,        4'd0, 4'd11, 1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h09000000, 8'hFF},
    // R9 end with number 0: no notice, resend
    '{3'd5, 32'h0A000000, 4'd0, 4'd9,  1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b1, 32'h0, 8'h00},
    // R9 priority copied
    '{3'd4, 32'h0,        4'd0, 4'd9,  1'b0, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 24'h0,  1'b0, 32'h0A000000, 8'hFF}
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    offer_valid = 1'b0; offer_src = '0; offer_prio = '0; offer_owner = '0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_wdata = '0;
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    if (v.kind == 3'd0) begin
      offer_valid = 1'b1; offer_src = v.w[23:0]; offer_prio = v.w[31:24]; offer_owner = v.own;
    end else begin
      cmd_valid = 1'b1; cmd_op = v.kind; cmd_wdata = v.w;
    end
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic poll_check(input int req, input logic [31:0] exp_word, input logic [7:0] exp_ipr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4;
    @(negedge clk);
    idle_inputs();
    chk(req, "poll valid", {31'd0, rd_valid}, 32'd1);
    chk(req, "poll word", rd_data, exp_word);
    chk(req, "poll ipr", {24'd0, rd_ipr}, {24'd0, exp_ipr});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(1, "irq after reset", {31'd0, irq_out}, 32'd0);
    poll_check(1, 32'h00000000, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v);
      chk(v.req, "irq", {31'd0, irq_out}, {31'd0, v.e_irq});
      chk(v.req, "nak", {31'd0, nak_valid}, {31'd0, v.e_nak});
      if (v.e_nak) begin
        chk(v.req, "nak src", {8'd0, nak_src}, {8'd0, v.w[23:0]});
        chk(v.req, "nak owner", {28'd0, nak_owner}, {28'd0, v.own});
      end
      chk(v.req, "rej", {31'd0, rej_valid}, {31'd0, v.e_rej});
      if (v.e_rej) begin
        chk(v.req, "rej src", {8'd0, rej_src}, {8'd0, v.e_rsrc});
        chk(v.req, "rej owner", {28'd0, rej_owner}, {28'd0, v.e_rown});
      end
      chk(v.req, "eoi", {31'd0, eoi_valid}, {31'd0, v.e_eoi});
      if (v.e_eoi) chk(v.req, "eoi src", {8'd0, eoi_src}, {8'd0, v.e_esrc});
      chk(v.req, "resend", {31'd0, resend_req}, {31'd0, v.e_res});
      chk(v.req, "rd valid", {31'd0, rd_valid}, {31'd0, (v.kind == 3'd3 || v.kind == 3'd4)});
      if (v.kind == 3'd3 || v.kind == 3'd4) begin
        chk(v.req, "rd word", rd_data, v.e_rd);
        chk(v.req, "rd ipr", {24'd0, rd_ipr}, {24'd0, v.e_ipr});
      end
    end

    // R11 offer in the same cycle as a poll is refused, not taken
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4;
    offer_valid = 1'b1; offer_src = 24'h80; offer_prio = 8'h01; offer_owner = 4'd8;
    @(negedge clk);
    idle_inputs();
    chk(11, "concurrent nak", {31'd0, nak_valid}, 32'd1);
    chk(11, "concurrent nak src", {8'd0, nak_src}, 32'h80);
    chk(11, "concurrent nak owner", {28'd0, nak_owner}, 32'd8);
    chk(11, "concurrent irq", {31'd0, irq_out}, 32'd0);
    chk(11, "concurrent poll", rd_data, 32'h0A000000);
    poll_check(11, 32'h0A000000, 8'hFF);

    // R8 request 0 below 0x0A, then R1 reset drops everything at once
    drive('{3'd2, 32'h0, 4'd0, 4'd8, 1'b1, 1'b0, 1'b0, 24'h0, 4'd0, 1'b0, 24'h0, 1'b0, 32'h0, 8'h00});
    chk(8, "request raises line", {31'd0, irq_out}, 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(1, "irq in reset", {31'd0, irq_out}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    poll_check(1, 32'h00000000, 8'hFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule